// File: doc/BRIEF.md
# LUT array emulator

This block emulates a small fabric of 4-input lookup tables. A W-bit state word holds one flip-flop per bit position. On every emulated clock, each bit takes a new value from its own 4-input truth table. The four inputs of that table are any four bits of the current state word, and the same bit may be chosen more than once. Truth tables are stored bit-sliced: there are 16 mask words, and mask word k holds, in bit position i, the output of function i for input combination k.

One emulated clock spans several real clocks, in this order:
- A single crossbar network is applied four times in succession, once under each of four routing tables. Each pass gathers one operand word into a pipeline register.
- The 16 minterm words of the four operands are formed and gated by the mask words. Their OR is registered.
- That result is committed to the state word, with a one-cycle done pulse.

Software loads the masks and routing tables through a write port while the block is idle. It then pulses `step_i` once for each emulated clock.

Top module: `lutemu_top`

## Requirements
- R1: After reset, `state_o` is zero, `done_o` is low, and every mask word and routing entry is zero. A step with no configuration written therefore leaves the state at zero.
- R2: A write with `cfg_wr_i` high while idle stores `cfg_wdata_i` as follows:
  - With address bit AW-1 clear, it goes to mask word k, where k is address bits [3:0].
  - With address bit AW-1 set, it goes to the routing entry of pass p = address bits [IW+1:IW] for bit i = address bits [IW-1:0]. Only the low IW data bits are kept. Pass 0, 1, 2 and 3 feed operands A, B, C and D.
- R3: The new state bit i equals bit i of mask word k, where k = A[i] + 2·B[i] + 4·C[i] + 8·D[i]. Operand bit X[i] is the state bit selected by routing entry i of that operand's pass.
- R4: Routing is unrestricted: any entry may name any state bit, and all four entries of one bit may name the same source.
- R5: A step sampled high while idle starts an emulated clock. The state updates and `done_o` rises on the sixth rising edge after that sample. `done_o` stays high for exactly one cycle.
- R6: A step sampled while an emulated clock is in progress is ignored. It neither restarts the sequence nor queues a second update.
- R7: Configuration writes issued while an emulated clock is in progress are ignored.
- R8: `state_o` changes only in the cycle in which `done_o` is high.
- R9: Each emulated clock evaluates from the state left by the previous one, so repeated steps iterate the emulated circuit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | AW | Configuration address (mask or routing entry) |
| cfg_wdata_i | input | W | Configuration write data |
| step_i | input | 1 | Start one emulated clock |
| done_o | output | 1 | One-cycle pulse when the state word updates |
| state_o | output | W | Current emulated state word |

## Verification
The bench builds the block with W = 16, which gives 4-bit routing entries and a 7-bit address. At this size a reference model in the bench can cover every minterm index across many random truth tables and routings. It can also follow multi-step feedback chains and exercise the 4-bit pass/index split of the routing address. The width is still small enough to drive bits by hand, so the bench can set up repeated-source routings and known constant states.

// File: rtl/lutemu_pkg.sv
package lutemu_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_MAP    = 2'd1,
        PH_EVAL   = 2'd2,
        PH_COMMIT = 2'd3
    } lutemu_phase_e;

    localparam int NMINTERM = 16;
    localparam int NPASS    = 4;

endpackage

// File: rtl/lutemu_cfg.sv
module lutemu_cfg
    import lutemu_pkg::*;
#(
    parameter int W  = 16,
    parameter int IW = 4,
    parameter int AW = 7
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en_i,
    input  logic [AW-1:0]                      addr_i,
    input  logic [W-1:0]                       wdata_i,
    input  logic [1:0]                         pass_i,
    output logic [NMINTERM-1:0][W-1:0]         mask_o,
    output logic [W-1:0][IW-1:0]               sel_o
);

    typedef struct packed {
        logic [NMINTERM-1:0][W-1:0]       mask;
        logic [NPASS-1:0][W-1:0][IW-1:0]  route;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            if (addr_i[AW-1]) begin
                cfg_d.route[addr_i[IW+1:IW]][addr_i[IW-1:0]] = wdata_i[IW-1:0];
            end else begin
                cfg_d.mask[addr_i[3:0]] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mask_o = cfg_q.mask;
    assign sel_o  = cfg_q.route[pass_i];

endmodule

// File: rtl/lutemu_xbar.sv
module lutemu_xbar #(
    parameter int W  = 16,
    parameter int IW = 4
) (
    input  logic [W-1:0]          src_i,
    input  logic [W-1:0][IW-1:0]  sel_i,
    output logic [W-1:0]          word_o
);

    for (genvar gi = 0; gi < W; gi++) begin : g_lane
        assign word_o[gi] = src_i[sel_i[gi]];
    end

endmodule

// File: rtl/lutemu_eval.sv
module lutemu_eval
    import lutemu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]                 op_a_i,
    input  logic [W-1:0]                 op_b_i,
    input  logic [W-1:0]                 op_c_i,
    input  logic [W-1:0]                 op_d_i,
    input  logic [NMINTERM-1:0][W-1:0]   mask_i,
    output logic [W-1:0]                 f_o
);

    logic [NMINTERM-1:0][W-1:0] minterm;

    for (genvar gk = 0; gk < NMINTERM; gk++) begin : g_min
        localparam logic [3:0] K = 4'(gk);
        assign minterm[gk] = (K[0] ? op_a_i : ~op_a_i)
                           & (K[1] ? op_b_i : ~op_b_i)
                           & (K[2] ? op_c_i : ~op_c_i)
                           & (K[3] ? op_d_i : ~op_d_i);
    end

    always_comb begin
        f_o = '0;
        for (int k = 0; k < NMINTERM; k++) begin
            f_o = f_o | (minterm[k] & mask_i[k]);
        end
    end

endmodule

// File: rtl/lutemu_top.sv
module lutemu_top
    import lutemu_pkg::*;
#(
    parameter  int W  = 16,
    localparam int IW = $clog2(W),
    localparam int AW = 1 + (((2 + IW) > 4) ? (2 + IW) : 4)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr_i,
    input  logic [AW-1:0]  cfg_addr_i,
    input  logic [W-1:0]   cfg_wdata_i,
    input  logic           step_i,
    output logic           done_o,
    output logic [W-1:0]   state_o
);

    typedef struct packed {
        lutemu_phase_e              phase;
        logic [1:0]                 pass;
        logic [NPASS-1:0][W-1:0]    opnd;
        logic [W-1:0]               result;
        logic [W-1:0]               state;
        logic                       done;
    } core_t;

    core_t core_d, core_q;

    logic                        cfg_wr_en;
    logic [NMINTERM-1:0][W-1:0]  mask_w;
    logic [W-1:0][IW-1:0]        sel_w;
    logic [W-1:0]                route_word;
    logic [W-1:0]                eval_word;

    assign cfg_wr_en = cfg_wr_i && (core_q.phase == PH_IDLE);

    lutemu_cfg #(.W(W), .IW(IW), .AW(AW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (cfg_wr_en),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .pass_i  (core_q.pass),
        .mask_o  (mask_w),
        .sel_o   (sel_w)
    );

    lutemu_xbar #(.W(W), .IW(IW)) u_xbar (
        .src_i  (core_q.state),
        .sel_i  (sel_w),
        .word_o (route_word)
    );

    lutemu_eval #(.W(W)) u_eval (
        .op_a_i (core_q.opnd[0]),
        .op_b_i (core_q.opnd[1]),
        .op_c_i (core_q.opnd[2]),
        .op_d_i (core_q.opnd[3]),
        .mask_i (mask_w),
        .f_o    (eval_word)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        unique case (core_q.phase)
            PH_IDLE: begin
                if (step_i) begin
                    core_d.phase = PH_MAP;
                    core_d.pass  = 2'd0;
                end
            end
            PH_MAP: begin
                core_d.opnd[core_q.pass] = route_word;
                if (core_q.pass == 2'(NPASS - 1)) core_d.phase = PH_EVAL;
                else                              core_d.pass  = core_q.pass + 2'd1;
            end
            PH_EVAL: begin
                core_d.result = eval_word;
                core_d.phase  = PH_COMMIT;
            end
            PH_COMMIT: begin
                core_d.state = core_q.result;
                core_d.done  = 1'b1;
                core_d.phase = PH_IDLE;
            end
            default: core_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign done_o  = core_q.done;
    assign state_o = core_q.state;

    // R5
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.phase == PH_IDLE && step_i) |=> (core_q.phase == PH_MAP && core_q.pass == 2'd0));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.phase != PH_IDLE) |=> !(core_q.phase == PH_MAP && core_q.pass == 2'd0));

    // R7
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.phase != PH_IDLE) |=> ($stable(mask_w) && $stable(u_cfg.cfg_q.route)));

    // R8
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_o) |-> done_o);

endmodule

// File: tb/lutemu_top_bench.sv
`timescale 1ns/1ps
module lutemu_top_bench;

    localparam int W  = 16;
    localparam int IW = $clog2(W);
    localparam int AW = 1 + (((2 + IW) > 4) ? (2 + IW) : 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_i = 1'b0;
    logic [AW-1:0] cfg_addr_i = '0;
    logic [W-1:0]  cfg_wdata_i = '0;
    logic          step_i = 1'b0;
    logic          done_o;
    logic [W-1:0]  state_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [W-1:0]  m_mask  [16];
    logic [IW-1:0] m_route [4][W];
    logic [W-1:0]  m_state;

    always #2.5 clk = ~clk;

    lutemu_top #(.W(W)) u_lutemu_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .step_i      (step_i),
        .done_o      (done_o),
        .state_o     (state_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_next(input logic [W-1:0] s);
        logic [W-1:0] n;
        for (int i = 0; i < W; i++) begin
            logic [3:0] k;
            k = {s[m_route[3][i]], s[m_route[2][i]], s[m_route[1][i]], s[m_route[0][i]]};
            n[i] = m_mask[k][i];
        end
        return n;
    endfunction

    function automatic logic [AW-1:0] route_addr(input int p, input int i);
        return AW'((1 << (AW - 1)) | (p << IW) | i);
    endfunction

    task automatic write_mask(input int k, input logic [W-1:0] v);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = AW'(k); cfg_wdata_i = v;
        @(negedge clk);
        cfg_wr_i = 1'b0;
        m_mask[k] = v;
    endtask

    task automatic write_route(input int p, input int i, input logic [IW-1:0] v);
        @(negedge clk);
        cfg_wr_i = 1'b1; cfg_addr_i = route_addr(p, i); cfg_wdata_i = W'(v);
        @(negedge clk);
        cfg_wr_i = 1'b0;
        m_route[p][i] = v;
    endtask

    // One emulated clock; checks latency, the one-cycle pulse and the new state.
    task automatic do_step(input string tag);
        logic [W-1:0] exp;
        int cnt;
        exp = model_next(m_state);
        @(negedge clk); step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
        cnt = 0;
        while (!done_o && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 6, {tag, " R5 latency"}, 32'(cnt), 32'd6);
        check(state_o == exp, {tag, " state"}, 32'(state_o), 32'(exp));
        m_state = exp;
        @(negedge clk);
        check(done_o == 1'b0, {tag, " R5 single pulse"}, 32'(done_o), 32'd0);
    endtask

    task automatic t_reset;
        check(state_o == '0, "R1 reset state", 32'(state_o), 32'd0);
        check(done_o == 1'b0, "R1 reset done", 32'(done_o), 32'd0);
        do_step("R1 zero config");
    endtask

    task automatic t_constant;
        // R2 R3: only minterm 0 set, all routes at bit 0
        write_mask(0, 16'hA5C3);
        do_step("R3 minterm0");
        // R9: state bit 0 is now 1 so every bit sees index 15, whose mask is 0
        do_step("R9 feedback");
        write_mask(15, 16'h0F0F);
        do_step("R9 second feedback");
    endtask

    task automatic t_random;
        for (int k = 0; k < 16; k++) write_mask(k, W'($urandom));
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < W; i++) write_route(p, i, IW'($urandom));
        // R4: all four inputs of bit 3 from bit 5, bit 9 from itself
        for (int p = 0; p < 4; p++) begin
            write_route(p, 3, IW'(5));
            write_route(p, 9, IW'(9));
        end
        for (int n = 0; n < 6; n++) do_step("R3 R4 R9 random");
    endtask

    task automatic t_busy_step;
        logic [W-1:0] exp;
        int cnt;
        int extra;
        exp = model_next(m_state);
        @(negedge clk); step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
        @(negedge clk); @(negedge clk); step_i = 1'b1;   // mid-run request
        @(negedge clk); step_i = 1'b0;
        cnt = 3;
        while (!done_o && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == 6, "R6 latency with mid-run step", 32'(cnt), 32'd6);
        check(state_o == exp, "R6 single update", 32'(state_o), 32'(exp));
        m_state = exp;
        extra = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0, "R6 no queued step", 32'(extra), 32'd0);
        check(state_o == exp, "R8 state held while idle", 32'(state_o), 32'(exp));
    endtask

    task automatic t_busy_cfg;
        logic [W-1:0] exp;
        int cnt;
        exp = model_next(m_state);
        @(negedge clk); step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
        // writes during run, not recorded in the model
        for (int k = 0; k < 4; k++) begin
            cfg_wr_i = 1'b1;
            cfg_addr_i = (k < 2) ? AW'(k * 15) : route_addr(k, 1);
            cfg_wdata_i = ~m_mask[(k < 2) ? k * 15 : 0];
            @(negedge clk);
        end
        cfg_wr_i = 1'b0;
        cnt = 4;
        while (!done_o && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        check(state_o == exp, "R7 run unaffected", 32'(state_o), 32'(exp));
        m_state = exp;
        @(negedge clk);
        do_step("R7 config unchanged");
        do_step("R7 config unchanged again");
    endtask

    initial begin
        for (int k = 0; k < 16; k++) m_mask[k] = '0;
        for (int p = 0; p < 4; p++)
            for (int i = 0; i < W; i++) m_route[p][i] = '0;
        m_state = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_constant();
        t_random();
        t_busy_step();
        t_busy_cfg();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule